// File: doc/BRIEF.md
# Flash Erase Sequencer

This block is the register-level front end for erasing an on-chip flash array. Software talks to it through a simple write/read bus that reaches four targets: a clock divider register, a command register, a status register and the flash array itself. An erase is armed by a strict three-write sequence. The first write goes to the array and names the target. The second write puts an erase code into the command register. The third write is a 1 to the buffer-empty flag, and it launches the command. The block checks the order of these writes, the command code, whether the divider has been loaded since reset, and whether the region to be erased touches the protected address range. It then either starts a timed erase or raises a sticky error flag.

A sector erase aligns the given address down to its sector base and fills that whole sector with 0xFF. A mass erase ignores the address and fills the entire array. The erase runs for a fixed number of divided-clock ticks, and a completion flag then rises for software to poll. The array is a small behavioural memory. At reset it is loaded with a known non-erased pattern so that erased words can be told apart.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the status register reads 0xC0 (bit 7 buffer-empty = 1, bit 6 complete = 1, bit 5 protection violation = 0, bit 4 access error = 0), the divider register reads 0x00, and array word i reads {1'b0, i[6:0]}.
- R2: A divider write stores the value in bits 5:0 and sets the divider-loaded flag, read back as bit 7 of the divider register.
- R3: A sector erase (code 0x40) fills every word of the sector that holds the step-one address (aligned down to a multiple of SECTOR_WORDS) with 0xFF and leaves all other words unchanged. The complete flag rises exactly ERASE_TICKS*(divider+1) clock edges after the launching edge.
- R4: A valid launch clears both buffer-empty and complete at the launching edge. Buffer-empty is set again one edge later. Complete stays clear until the erase finishes.
- R5: A mass erase (code 0x41) fills every array word with 0xFF, whatever address was written in step one.
- R6: If protection is enabled and the sector to be erased overlaps [PROT_LO, PROT_HI], or the command is a mass erase, the launch sets protection violation (bit 5). No erase starts, buffer-empty stays 1 and the array is unchanged.
- R7: A command write that does not directly follow an array write, an unknown command code, or a launch write that does not directly follow a valid command write, sets access error (bit 4) and aborts the sequence without erasing.
- R8: A launch attempted while the divider-loaded flag is clear sets access error, and no erase starts.
- R9: Writing 1 to status bit 5 or bit 4 clears that flag. While either flag is set, an array write is not accepted as step one and sets access error.
- R10: During an erase, array and command writes set access error and are otherwise ignored. The erase and the command register are not affected.
- R11: The command register reads back the last accepted command code. A rejected code does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_tgt | input | 2 | Write target: 0 divider, 1 command, 2 status, 3 array |
| wr_addr | input | ADDR_W | Array word address for array writes |
| wr_data | input | 8 | Write data |
| rd_tgt | input | 2 | Read target, same encoding as wr_tgt |
| rd_addr | input | ADDR_W | Array word address for array reads |
| rd_data | output | 8 | Combinational read data |

## Verification
The hardest state to reach from the ports is the launch edge itself. Buffer-empty drops for a single cycle there, and the erase latency is counted from that edge, so the bench tracks a free-running cycle counter and samples status on the two cycles right after the launch write. It then issues array and command writes while the erase is still running, to show that they are rejected without disturbing the timing. The cases that need protection switched off are driven on a second instance built with protection disabled. A table walks the error paths in sequence, so each abort is followed by a flag clear and a fresh attempt, and that attempt shows whether the aborted step was accepted.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        TGT_DIV  = 2'd0,
        TGT_CMD  = 2'd1,
        TGT_STAT = 2'd2,
        TGT_ARR  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_CMD,
        SQ_BUSY
    } seq_e;

    localparam logic [7:0] CODE_SECTOR = 8'h40;
    localparam logic [7:0] CODE_MASS   = 8'h41;

    localparam int BIT_CBE = 7;
    localparam int BIT_CCF = 6;
    localparam int BIT_PV  = 5;
    localparam int BIT_AE  = 4;

    typedef struct packed {
        logic cbe;
        logic ccf;
        logic pv;
        logic ae;
    } flags_t;

    function automatic logic [7:0] fill_pattern(input logic [6:0] idx);
        return {1'b0, idx};
    endfunction

    function automatic logic [7:0] pack_status(input flags_t f);
        return {f.cbe, f.ccf, f.pv, f.ae, 4'b0000};
    endfunction

    function automatic logic code_known(input logic [7:0] code);
        return (code == CODE_SECTOR) || (code == CODE_MASS);
    endfunction

endpackage

// File: rtl/flash_seq_prot.sv
module flash_seq_prot #(
    parameter int ADDR_W    = 8,
    parameter int SEC_SHIFT = 5,
    parameter bit PROT_EN   = 1'b1,
    parameter int PROT_LO   = 0,
    parameter int PROT_HI   = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mass,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] SEC_MASK = ADDR_W'((1 << SEC_SHIFT) - 1);
    localparam logic [ADDR_W-1:0] LO_A     = ADDR_W'(PROT_LO);
    localparam logic [ADDR_W-1:0] HI_A     = ADDR_W'(PROT_HI);

    logic [ADDR_W-1:0] sec_base;
    logic [ADDR_W-1:0] sec_last;
    logic              overlap;

    always_comb begin
        sec_base = addr & ~SEC_MASK;
        sec_last = sec_base | SEC_MASK;
        overlap  = !((sec_last < LO_A) || (sec_base > HI_A));
        hit      = PROT_EN && (mass || overlap);
    end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int DIV_W       = 6,
    parameter int ERASE_TICKS = 4,
    localparam int TICK_W     = $clog2(ERASE_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             done
);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(ERASE_TICKS - 1);

    logic [DIV_W-1:0]  pre_q;
    logic [TICK_W-1:0] tick_q;
    logic              tick;

    assign tick = (pre_q == div);
    assign done = run && tick && (tick_q == LAST_TICK);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (tick) begin
            pre_q  <= '0;
            tick_q <= tick_q + 1'b1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array
    import flash_seq_pkg::*;
#(
    parameter int WORDS     = 256,
    parameter int ADDR_W    = 8,
    parameter int SEC_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] erase_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic [7:0] cells [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [ADDR_W-1:0] GA = ADDR_W'(g);
        logic [7:0] cell_q;
        logic       in_sector;

        assign in_sector = ((erase_addr >> SEC_SHIFT) == (GA >> SEC_SHIFT));

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= fill_pattern(7'(g));
            end else if (erase && (erase_all || in_sector)) begin
                cell_q <= 8'hFF;
            end
        end

        assign cells[g] = cell_q;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIV_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  tgt_e              wr_tgt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prot_hit,
    input  logic              erase_done,
    output flags_t            flags,
    output logic              div_ok,
    output logic [DIV_W-1:0]  div_q,
    output logic [7:0]        cmd_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              busy
);
    seq_e state;

    assign busy = (state == SQ_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            flags  <= '{cbe: 1'b1, ccf: 1'b1, pv: 1'b0, ae: 1'b0};
            div_ok <= 1'b0;
            div_q  <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
        end else begin
            if (state == SQ_BUSY) begin
                flags.cbe <= 1'b1;
                if (erase_done) begin
                    flags.ccf <= 1'b1;
                    state     <= SQ_IDLE;
                end
            end
            if (wr_en) begin
                unique case (wr_tgt)
                    TGT_DIV: begin
                        if (state != SQ_BUSY) begin
                            div_q  <= wr_data[DIV_W-1:0];
                            div_ok <= 1'b1;
                        end
                    end
                    TGT_ARR: begin
                        if (state == SQ_IDLE && !flags.pv && !flags.ae) begin
                            addr_q <= wr_addr;
                            state  <= SQ_ADDR;
                        end else begin
                            flags.ae <= 1'b1;
                            if (state != SQ_BUSY) state <= SQ_IDLE;
                        end
                    end
                    TGT_CMD: begin
                        if (state == SQ_ADDR && code_known(wr_data)) begin
                            cmd_q <= wr_data;
                            state <= SQ_CMD;
                        end else begin
                            flags.ae <= 1'b1;
                            if (state != SQ_BUSY) state <= SQ_IDLE;
                        end
                    end
                    TGT_STAT: begin
                        if (wr_data[BIT_PV]) flags.pv <= 1'b0;
                        if (wr_data[BIT_AE]) flags.ae <= 1'b0;
                        if (wr_data[BIT_CBE]) begin
                            if (state == SQ_CMD) begin
                                if (!div_ok) begin
                                    flags.ae <= 1'b1;
                                    state    <= SQ_IDLE;
                                end else if (prot_hit) begin
                                    flags.pv <= 1'b1;
                                    state    <= SQ_IDLE;
                                end else begin
                                    flags.cbe <= 1'b0;
                                    flags.ccf <= 1'b0;
                                    state     <= SQ_BUSY;
                                end
                            end else begin
                                flags.ae <= 1'b1;
                                if (state != SQ_BUSY) state <= SQ_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_seq_pkg::*;
#(
    parameter int WORDS        = 256,
    parameter int SECTOR_WORDS = 32,
    parameter int DIV_W        = 6,
    parameter int ERASE_TICKS  = 4,
    parameter bit PROT_EN      = 1'b1,
    parameter int PROT_LO      = 192,
    parameter int PROT_HI      = 223,
    localparam int ADDR_W      = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_tgt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        rd_tgt,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int SEC_SHIFT = $clog2(SECTOR_WORDS);

    flags_t            flags_q;
    logic              div_ok;
    logic [DIV_W-1:0]  div_q;
    logic [7:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              busy;
    logic              prot_hit;
    logic              erase_done;
    logic              is_mass;
    logic [7:0]        arr_rd;
    logic [7:0]        div_rd;

    assign is_mass = (cmd_q == CODE_MASS);

    flash_seq_ctrl #(
        .ADDR_W (ADDR_W),
        .DIV_W  (DIV_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_tgt     (tgt_e'(wr_tgt)),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .prot_hit   (prot_hit),
        .erase_done (erase_done),
        .flags      (flags_q),
        .div_ok     (div_ok),
        .div_q      (div_q),
        .cmd_q      (cmd_q),
        .addr_q     (addr_q),
        .busy       (busy)
    );

    flash_seq_prot #(
        .ADDR_W    (ADDR_W),
        .SEC_SHIFT (SEC_SHIFT),
        .PROT_EN   (PROT_EN),
        .PROT_LO   (PROT_LO),
        .PROT_HI   (PROT_HI)
    ) prot_i (
        .addr (addr_q),
        .mass (is_mass),
        .hit  (prot_hit)
    );

    flash_seq_timer #(
        .DIV_W       (DIV_W),
        .ERASE_TICKS (ERASE_TICKS)
    ) timer_i (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (div_q),
        .done (erase_done)
    );

    flash_seq_array #(
        .WORDS     (WORDS),
        .ADDR_W    (ADDR_W),
        .SEC_SHIFT (SEC_SHIFT)
    ) array_i (
        .clk        (clk),
        .rst        (rst),
        .erase      (erase_done),
        .erase_all  (is_mass),
        .erase_addr (addr_q),
        .rd_addr    (rd_addr),
        .rd_data    (arr_rd)
    );

    always_comb begin
        div_rd    = 8'(div_q);
        div_rd[7] = div_ok;
        unique case (tgt_e'(rd_tgt))
            TGT_DIV:  rd_data = div_rd;
            TGT_CMD:  rd_data = cmd_q;
            TGT_STAT: rd_data = pack_status(flags_q);
            TGT_ARR:  rd_data = arr_rd;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cbe,
    input logic       ccf,
    input logic       pv,
    input logic       ae,
    input logic       div_ok,
    input logic       busy,
    input logic       wr_en,
    input logic [1:0] wr_tgt
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cbe && ccf && !pv && !ae && !div_ok && !busy));

    assert_cbe_returns_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(cbe) |=> cbe);

    assert_no_ccf_busy_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ccf);

    assert_done_needs_div_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ccf) |-> div_ok);

    assert_pv_no_launch_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pv) |-> (cbe && $past(cbe) && !busy));

    assert_busy_arr_write_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && wr_tgt == 2'd3) |=> ae);
endmodule

bind flash_erase_seq flash_seq_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .cbe    (flags_q.cbe),
    .ccf    (flags_q.ccf),
    .pv     (flags_q.pv),
    .ae     (flags_q.ae),
    .div_ok (div_ok),
    .busy   (busy),
    .wr_en  (wr_en),
    .wr_tgt (wr_tgt)
);

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
    localparam int NV = 46;
    localparam logic [1:0] T_DIV = 2'd0, T_CMD = 2'd1, T_STAT = 2'd2, T_ARR = 2'd3;

    // {op(1: read-check, 0: write), target(2), pad(1), requirement(4), addr(8), data(8)}
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, T_STAT, 1'b0, 4'd1,  8'h00, 8'hC0},  // R1 status reset
        {1'b1, T_DIV,  1'b0, 4'd1,  8'h00, 8'h00},  // R1 divider reset
        {1'b1, T_ARR,  1'b0, 4'd1,  8'h05, 8'h05},  // R1 pattern
        {1'b1, T_ARR,  1'b0, 4'd1,  8'h93, 8'h13},  // R1 pattern
        {1'b0, T_CMD,  1'b0, 4'd7,  8'h00, 8'h40},  // R7 command with no step one
        {1'b1, T_STAT, 1'b0, 4'd7,  8'h00, 8'hD0},  // R7
        {1'b0, T_ARR,  1'b0, 4'd9,  8'h10, 8'h00},  // R9 start with flag set
        {1'b1, T_STAT, 1'b0, 4'd9,  8'h00, 8'hD0},  // R9
        {1'b0, T_STAT, 1'b0, 4'd9,  8'h00, 8'h10},  // R9 clear ae
        {1'b1, T_STAT, 1'b0, 4'd9,  8'h00, 8'hC0},  // R9
        {1'b0, T_CMD,  1'b0, 4'd9,  8'h00, 8'h40},  // R9 step one was refused
        {1'b1, T_STAT, 1'b0, 4'd9,  8'h00, 8'hD0},  // R9
        {1'b0, T_STAT, 1'b0, 4'd9,  8'h00, 8'h30},  // R9
        {1'b0, T_ARR,  1'b0, 4'd7,  8'h20, 8'h00},  // R7
        {1'b0, T_CMD,  1'b0, 4'd7,  8'h00, 8'h55},  // R7 unknown code
        {1'b1, T_STAT, 1'b0, 4'd7,  8'h00, 8'hD0},  // R7
        {1'b1, T_CMD,  1'b0, 4'd11, 8'h00, 8'h00},  // R11 rejected code not stored
        {1'b0, T_STAT, 1'b0, 4'd9,  8'h00, 8'h10},  // R9
        {1'b0, T_ARR,  1'b0, 4'd8,  8'h20, 8'h00},  // R8
        {1'b0, T_CMD,  1'b0, 4'd8,  8'h00, 8'h40},  // R8
        {1'b1, T_CMD,  1'b0, 4'd11, 8'h00, 8'h40},  // R11
        {1'b0, T_STAT, 1'b0, 4'd8,  8'h00, 8'h80},  // R8 launch, no divider
        {1'b1, T_STAT, 1'b0, 4'd8,  8'h00, 8'hD0},  // R8
        {1'b1, T_ARR,  1'b0, 4'd8,  8'h20, 8'h20},  // R8 untouched
        {1'b0, T_STAT, 1'b0, 4'd9,  8'h00, 8'h10},  // R9
        {1'b0, T_DIV,  1'b0, 4'd2,  8'h00, 8'h01},  // R2
        {1'b1, T_DIV,  1'b0, 4'd2,  8'h00, 8'h81},  // R2
        {1'b0, T_ARR,  1'b0, 4'd7,  8'h20, 8'h00},  // R7
        {1'b0, T_STAT, 1'b0, 4'd7,  8'h00, 8'h80},  // R7 launch with command skipped
        {1'b1, T_STAT, 1'b0, 4'd7,  8'h00, 8'hD0},  // R7
        {1'b1, T_ARR,  1'b0, 4'd7,  8'h20, 8'h20},  // R7 untouched
        {1'b0, T_STAT, 1'b0, 4'd9,  8'h00, 8'h10},  // R9
        {1'b0, T_ARR,  1'b0, 4'd6,  8'hC5, 8'h00},  // R6 protected sector
        {1'b0, T_CMD,  1'b0, 4'd6,  8'h00, 8'h40},  // R6
        {1'b0, T_STAT, 1'b0, 4'd6,  8'h00, 8'h80},  // R6
        {1'b1, T_STAT, 1'b0, 4'd6,  8'h00, 8'hE0},  // R6
        {1'b1, T_ARR,  1'b0, 4'd6,  8'hC5, 8'h45},  // R6 untouched
        {1'b0, T_STAT, 1'b0, 4'd9,  8'h00, 8'h20},  // R9 clear pv
        {1'b1, T_STAT, 1'b0, 4'd9,  8'h00, 8'hC0},  // R9
        {1'b0, T_ARR,  1'b0, 4'd6,  8'h00, 8'h00},  // R6 mass with protection
        {1'b0, T_CMD,  1'b0, 4'd6,  8'h00, 8'h41},  // R6
        {1'b0, T_STAT, 1'b0, 4'd6,  8'h00, 8'h80},  // R6
        {1'b1, T_STAT, 1'b0, 4'd6,  8'h00, 8'hE0},  // R6
        {1'b1, T_ARR,  1'b0, 4'd6,  8'h00, 8'h00},  // R6 untouched
        {1'b0, T_STAT, 1'b0, 4'd9,  8'h00, 8'h20},  // R9
        {1'b1, T_STAT, 1'b0, 4'd9,  8'h00, 8'hC0}   // R9
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_tgt = 2'd0;
    logic [7:0] wr_addr = 8'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_tgt = 2'd0;
    logic [7:0] rd_addr = 8'd0;
    logic [7:0] rd_a, rd_b, rd_data;
    logic       wr_a, wr_b;
    int         n_tests = 0;
    int         n_fail = 0;
    int         cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign wr_a    = wr_en && !sel;
    assign wr_b    = wr_en && sel;
    assign rd_data = sel ? rd_b : rd_a;

    flash_erase_seq dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_a), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_tgt(rd_tgt), .rd_addr(rd_addr), .rd_data(rd_a)
    );

    flash_erase_seq #(.PROT_EN(1'b0)) dut_np_i (
        .clk(clk), .rst(rst), .wr_en(wr_b), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_tgt(rd_tgt), .rd_addr(rd_addr), .rd_data(rd_b)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] tgt, input logic [7:0] addr, input logic [7:0] data);
        wr_en = 1'b1; wr_tgt = tgt; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] tgt,
                          input logic [7:0] addr, input logic [7:0] exp);
        rd_tgt = tgt; rd_addr = addr;
        #1;
        check(req, rd_data, exp);
        @(negedge clk);
    endtask

    task automatic wait_ccf(input string req, input int start, input int exp_lat);
        logic seen = 1'b0;
        for (int k = 0; k < 300 && !seen; k++) begin
            rd_tgt = T_STAT;
            #1;
            if (rd_data[6]) seen = 1'b1;
            else @(negedge clk);
        end
        check(req, 8'(cyc - start), 8'(exp_lat));
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R3: watchdog got no completion expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][19:16], i);
            if (VEC[i][23]) rd_chk(tag, VEC[i][22:21], VEC[i][15:8], VEC[i][7:0]);
            else            wr(VEC[i][22:21], VEC[i][15:8], VEC[i][7:0]);
        end

        // R3 / R4 / R10 / R11: sector erase, divider 1, four ticks
        wr(T_ARR, 8'h47, 8'h00);
        wr(T_CMD, 8'h00, 8'h40);
        wr(T_STAT, 8'h00, 8'h80);
        c0 = cyc;
        rd_chk("R4 launch edge", T_STAT, 8'h00, 8'h00);
        rd_chk("R4 cbe back", T_STAT, 8'h00, 8'h80);
        wr(T_ARR, 8'h10, 8'h00);
        wr(T_CMD, 8'h00, 8'h41);
        rd_chk("R10 R11 cmd kept", T_CMD, 8'h00, 8'h40);
        wait_ccf("R3 latency", c0, 8);
        rd_chk("R10 ae after busy writes", T_STAT, 8'h00, 8'hD0);
        rd_chk("R3 below sector", T_ARR, 8'h3F, 8'h3F);
        rd_chk("R3 sector base", T_ARR, 8'h40, 8'hFF);
        rd_chk("R3 sector mid", T_ARR, 8'h47, 8'hFF);
        rd_chk("R3 sector end", T_ARR, 8'h5F, 8'hFF);
        rd_chk("R3 above sector", T_ARR, 8'h60, 8'h60);

        // R1: reset again restores everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_chk("R1 status after reset", T_STAT, 8'h00, 8'hC0);
        rd_chk("R1 div after reset", T_DIV, 8'h00, 8'h00);
        rd_chk("R1 array after reset", T_ARR, 8'h40, 8'h40);

        // R5: mass erase on the unprotected instance, divider 0
        sel = 1'b1;
        wr(T_DIV, 8'h00, 8'h00);
        rd_chk("R2 div zero loaded", T_DIV, 8'h00, 8'h80);
        wr(T_ARR, 8'h33, 8'h00);
        wr(T_CMD, 8'h00, 8'h41);
        wr(T_STAT, 8'h00, 8'h80);
        c0 = cyc;
        wait_ccf("R5 latency", c0, 4);
        rd_chk("R5 status", T_STAT, 8'h00, 8'hC0);
        rd_chk("R5 word 0", T_ARR, 8'h00, 8'hFF);
        rd_chk("R5 word 80", T_ARR, 8'h80, 8'hFF);
        rd_chk("R5 word FF", T_ARR, 8'hFF, 8'hFF);
        rd_chk("R11 mass code", T_CMD, 8'h00, 8'h41);
        sel = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule